// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block corrects the red, green and blue components of a pixel stream through a lookup table, for several display channels that share one stream. Every pixel arrives with a channel index and three 8-bit components. When gamma is switched on for that channel, each component is replaced by the table entry for its value. When gamma is off, or the channel index names no channel, the pixel passes through unchanged. The valid and sync sidebands go through the same single register stage as the pixel.

All channels share one table of `NUM_CH * 3 * 256` 8-bit entries. Software loads it through two write ports. The address port sets a write pointer and a step flag. The data port stores the high byte of a 16-bit correction word at the pointer. If the step flag is set, the pointer then advances by one. A block of writes can therefore load a channel's three tables one after another, or the whole memory.

Top module: `gamma_lut_multi`

## Requirements
- R1: After reset every table entry holds its own value: entry for component value v is v, for all channels and components.
- R2: The entry used for channel c, component k (red=0, green=1, blue=2) and value v is at address (c*3 + k)*256 + v.
- R3: A data write stores bits [15:8] of `cfg_data_val` at the write pointer; bits [7:0] are discarded.
- R4: When the step flag (`cfg_addr_inc`, captured with the address) is 1, each data write advances the write pointer by one.
- R5: When the step flag is 0, repeated data writes go to the same address, and the last write is kept.
- R6: A stepping data write at address NUM_CH*768-1 moves the pointer to address 0.
- R7: An address load at or above NUM_CH*768 sets the write pointer to 0.
- R8: Each channel c has its own enable `chan_gamma_en[c]`. When it is 0, that channel's pixels leave with their input values.
- R9: A pixel whose channel index is NUM_CH or above passes through unchanged, whatever the enables are.
- R10: Outputs appear exactly one clock after the input. `out_valid`, `out_hsync` and `out_vsync` are the inputs delayed by one clock, including when `in_valid` is 0. Reset clears all three.
- R11: A lookup made in the same cycle as a table write to the same entry returns the entry's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_we | input | 1 | Loads write pointer and step flag |
| cfg_addr_val | input | 12 | Write pointer value |
| cfg_addr_inc | input | 1 | Step flag value |
| cfg_data_we | input | 1 | Table data write strobe |
| cfg_data_val | input | 16 | Correction word; high byte is stored |
| chan_gamma_en | input | 3 | Per-channel gamma enable |
| in_valid | input | 1 | Input pixel valid |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync |
| in_chan | input | 2 | Input pixel channel index |
| in_r | input | 8 | Input red |
| in_g | input | 8 | Input green |
| in_b | input | 8 | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_hsync | output | 1 | Output horizontal sync |
| out_vsync | output | 1 | Output vertical sync |
| out_chan | output | 2 | Output channel index |
| out_r | output | 8 | Output red |
| out_g | output | 8 | Output green |
| out_b | output | 8 | Output blue |

## Verification
A pixel's corrected components and its sidebands are due at the first rising edge after the pixel is presented. The bench drives each pixel on a falling edge and compares the outputs on the next falling edge. A table write takes effect at its own rising edge, so it is seen by the next pixel onward but not by a pixel in the same cycle; the R11 check presents both together and then reads the entry again. Pointer behaviour is observed only through pixels that read back the entries the writes should have reached.

// File: rtl/glut_pkg.sv
package glut_pkg;
  localparam int COMP_W   = 8;
  localparam int ENTRIES  = 1 << COMP_W;
  localparam int COMP_NUM = 3;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb_t;

  function automatic int lut_depth(input int nch);
    return nch * COMP_NUM * ENTRIES;
  endfunction
endpackage

// File: rtl/glut_wr_ptr.sv
module glut_wr_ptr
  import glut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              addr_inc,
  input  logic              data_we,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam int DEPTH = lut_depth(NUM_CH);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              inc_q, inc_d;
  logic              ptr_ce;

  always_comb begin
    ptr_d  = ptr_q;
    inc_d  = inc_q;
    ptr_ce = 1'b0;
    if (addr_we) begin
      ptr_ce = 1'b1;
      inc_d  = addr_inc;
      ptr_d  = (int'(addr_val) < DEPTH) ? addr_val : '0;
    end else if (data_we && inc_q) begin
      ptr_ce = 1'b1;
      ptr_d  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      inc_q <= 1'b0;
    end else if (ptr_ce) begin
      ptr_q <= ptr_d;
      inc_q <= inc_d;
    end
  end

  assign wr_en   = data_we;
  assign wr_addr = ptr_q;

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < DEPTH);

  // R4 R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && inc_q && !addr_we) |=>
      (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !inc_q && !addr_we) |=> $stable(ptr_q));
endmodule

// File: rtl/glut_store.sv
module glut_store
  import glut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [COMP_W-1:0] wr_byte,
  input  logic [ADDR_W-1:0] rd_addr [COMP_NUM],
  output logic [COMP_W-1:0] rd_data [COMP_NUM]
);
  localparam int DEPTH = lut_depth(NUM_CH);

  logic [COMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= COMP_W'(i % ENTRIES);
    end else if (wr_en) begin
      mem[wr_addr] <= wr_byte;
    end
  end

  for (genvar k = 0; k < COMP_NUM; k++) begin : g_rd
    assign rd_data[k] = mem[rd_addr[k]];
  end

  // R3
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_byte)));
endmodule

// File: rtl/glut_pix_path.sv
module glut_pix_path
  import glut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              in_valid,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic [CH_W-1:0]   in_chan,
  input  rgb_t              in_pix,
  output logic [ADDR_W-1:0] rd_addr [COMP_NUM],
  input  logic [COMP_W-1:0] rd_data [COMP_NUM],
  output logic              out_valid,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic [CH_W-1:0]   out_chan,
  output rgb_t              out_pix
);
  logic              chan_ok;
  logic              use_lut;
  logic [COMP_W-1:0] comp_val [COMP_NUM];
  rgb_t              pix_d;
  logic              valid_q, hs_q, vs_q;
  logic [CH_W-1:0]   chan_q;
  rgb_t              pix_q;

  assign chan_ok     = int'(in_chan) < NUM_CH;
  assign comp_val[0] = in_pix.r;
  assign comp_val[1] = in_pix.g;
  assign comp_val[2] = in_pix.b;

  always_comb begin
    use_lut = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (int'(in_chan) == k) use_lut = gamma_en[k];
    end
  end

  for (genvar k = 0; k < COMP_NUM; k++) begin : g_addr
    assign rd_addr[k] = chan_ok
      ? ADDR_W'((int'(in_chan) * COMP_NUM + k) * ENTRIES + int'(comp_val[k]))
      : '0;
  end

  always_comb begin
    pix_d.r = use_lut ? rd_data[0] : in_pix.r;
    pix_d.g = use_lut ? rd_data[1] : in_pix.g;
    pix_d.b = use_lut ? rd_data[2] : in_pix.b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      hs_q    <= in_hsync;
      vs_q    <= in_vsync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      pix_q  <= '0;
    end else if (in_valid) begin
      chan_q <= in_chan;
      pix_q  <= pix_d;
    end
  end

  assign out_valid = valid_q;
  assign out_hsync = hs_q;
  assign out_vsync = vs_q;
  assign out_chan  = chan_q;
  assign out_pix   = pix_q;

  // R10
  side_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid) && out_hsync == $past(in_hsync)
              && out_vsync == $past(in_vsync)));

  // R8 R9
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (!chan_ok || ((gamma_en >> in_chan) & 1) == 0))
      |=> (out_pix == $past(in_pix)));
endmodule

// File: rtl/gamma_lut_multi.sv
module gamma_lut_multi
  import glut_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W = $clog2(NUM_CH * 3 * 256)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_addr_we,
  input  logic [ADDR_W-1:0] cfg_addr_val,
  input  logic              cfg_addr_inc,
  input  logic              cfg_data_we,
  input  logic [15:0]       cfg_data_val,
  input  logic [NUM_CH-1:0] chan_gamma_en,
  input  logic              in_valid,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [7:0]        in_r,
  input  logic [7:0]        in_g,
  input  logic [7:0]        in_b,
  output logic              out_valid,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic [CH_W-1:0]   out_chan,
  output logic [7:0]        out_r,
  output logic [7:0]        out_g,
  output logic [7:0]        out_b
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr [COMP_NUM];
  logic [COMP_W-1:0] rd_data [COMP_NUM];
  rgb_t              in_pix, out_pix;

  assign in_pix = '{r: in_r, g: in_g, b: in_b};

  glut_wr_ptr #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_ptr (
    .clk(clk), .rst_n(rst_n),
    .addr_we(cfg_addr_we), .addr_val(cfg_addr_val), .addr_inc(cfg_addr_inc),
    .data_we(cfg_data_we), .wr_en(wr_en), .wr_addr(wr_addr)
  );

  glut_store #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(cfg_data_val[15:8]),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  glut_pix_path #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) i_path (
    .clk(clk), .rst_n(rst_n), .gamma_en(chan_gamma_en),
    .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .in_chan(in_chan), .in_pix(in_pix),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_chan(out_chan), .out_pix(out_pix)
  );

  assign out_r = out_pix.r;
  assign out_g = out_pix.g;
  assign out_b = out_pix.b;
endmodule

// File: tb/test_gamma_lut_multi.sv
module test_gamma_lut_multi;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 3;
  localparam int DEPTH = NCH * 3 * 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_addr_we, cfg_addr_inc, cfg_data_we;
  logic [11:0] cfg_addr_val;
  logic [15:0] cfg_data_val;
  logic [2:0]  chan_gamma_en;
  logic        in_valid, in_hsync, in_vsync;
  logic [1:0]  in_chan;
  logic [7:0]  in_r, in_g, in_b;
  logic        out_valid, out_hsync, out_vsync;
  logic [1:0]  out_chan;
  logic [7:0]  out_r, out_g, out_b;

  int n_chk = 0;
  int n_bad = 0;
  int exp_tab [DEPTH];
  int bptr = 0;
  bit binc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_lut_multi i_gamma_lut_multi (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr_we(cfg_addr_we), .cfg_addr_val(cfg_addr_val),
    .cfg_addr_inc(cfg_addr_inc), .cfg_data_we(cfg_data_we),
    .cfg_data_val(cfg_data_val), .chan_gamma_en(chan_gamma_en),
    .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync),
    .in_chan(in_chan), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_chan(out_chan), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_addr(int a, bit inc);
    cfg_addr_we = 1'b1; cfg_addr_val = 12'(a); cfg_addr_inc = inc;
    @(negedge clk);
    cfg_addr_we = 1'b0;
    bptr = (a < DEPTH) ? a : 0;
    binc = inc;
  endtask

  task automatic put_data(int v);
    cfg_data_we = 1'b1; cfg_data_val = 16'(v);
    @(negedge clk);
    cfg_data_we = 1'b0;
    exp_tab[bptr] = (v >> 8) & 255;
    if (binc) bptr = (bptr == DEPTH - 1) ? 0 : bptr + 1;
  endtask

  function automatic int expect_c(int ch, int k, int v);
    if (ch < NCH && chan_gamma_en[ch]) return exp_tab[(ch * 3 + k) * 256 + v];
    return v;
  endfunction

  task automatic pix_check(int ch, int r, int g, int b, bit hs, bit vs, string req);
    int er, eg, eb;
    er = expect_c(ch, 0, r); eg = expect_c(ch, 1, g); eb = expect_c(ch, 2, b);
    in_valid = 1'b1; in_chan = 2'(ch); in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
    in_hsync = hs; in_vsync = vs;
    @(negedge clk);
    in_valid = 1'b0; in_hsync = 1'b0; in_vsync = 1'b0;
    check(out_valid && out_hsync == hs && out_vsync == vs && int'(out_chan) == ch,
          req, "sidebands", {out_valid, out_hsync, out_vsync, out_chan},
          {1'b1, hs, vs, 2'(ch)});
    check(out_r == 8'(er) && out_g == 8'(eg) && out_b == 8'(eb), req, "rgb",
          {out_r, out_g, out_b}, {8'(er), 8'(eg), 8'(eb)});
  endtask

  task automatic sweep(string req);
    for (int ch = 0; ch < NCH; ch++)
      for (int v = 0; v < 256; v++)
        pix_check(ch, v, 255 - v, (v * 37 + 11) & 255, v[0], v == 0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_addr_we = 0; cfg_addr_inc = 0; cfg_data_we = 0;
    cfg_addr_val = '0; cfg_data_val = '0; chan_gamma_en = 3'b111;
    in_valid = 0; in_hsync = 0; in_vsync = 0; in_chan = '0;
    in_r = '0; in_g = '0; in_b = '0;
    for (int i = 0; i < DEPTH; i++) exp_tab[i] = i % 256;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!out_valid && !out_hsync && !out_vsync, "R10", "reset sidebands",
          {out_valid, out_hsync, out_vsync}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 sidebands move with valid low
    in_hsync = 1'b1;
    @(negedge clk);
    in_hsync = 1'b0; in_vsync = 1'b1;
    check(!out_valid && out_hsync && !out_vsync, "R10", "idle hsync",
          {out_valid, out_hsync, out_vsync}, 3'b010);
    @(negedge clk);
    in_vsync = 1'b0;
    check(!out_valid && !out_hsync && out_vsync, "R10", "idle vsync",
          {out_valid, out_hsync, out_vsync}, 3'b001);
    @(negedge clk);

    // R1 identity ramp after reset
    sweep("R1");

    // R2 R3 R4 full load with stepping pointer, low byte is noise
    load_addr(0, 1'b1);
    for (int i = 0; i < DEPTH; i++)
      put_data(((((i * 97) + (i >> 8) * 13) & 255) << 8) | ((i & 255) ^ 8'hA5));
    sweep("R2 R3 R4");

    // R8 per-channel enables
    chan_gamma_en = 3'b101;
    sweep("R8");
    chan_gamma_en = 3'b000;
    sweep("R8");
    chan_gamma_en = 3'b111;

    // R9 out-of-range channel passes through
    for (int v = 0; v < 256; v += 17) pix_check(3, v, v ^ 255, (v + 5) & 255, 0, 0, "R9");

    // R5 no stepping: last write wins, neighbour untouched
    load_addr(256 * 4 + 77, 1'b0);
    put_data(16'h1100);
    put_data(16'h2200);
    put_data(16'h3344);
    pix_check(1, 0, 77, 0, 0, 0, "R5");
    pix_check(1, 0, 78, 0, 0, 0, "R5");

    // R6 wrap from last entry to zero
    load_addr(DEPTH - 1, 1'b1);
    put_data(16'hC3FF);
    put_data(16'h5A00);
    pix_check(2, 0, 0, 255, 0, 0, "R6");
    pix_check(0, 0, 0, 0, 0, 0, "R6");

    // R7 out-of-range address load lands on zero
    load_addr(3000, 1'b1);
    put_data(16'h9E12);
    pix_check(0, 0, 0, 0, 1, 1, "R7");

    // R11 lookup during a write to the same entry sees the old value
    load_addr(256 * 4 + 10, 1'b0);
    begin
      int old_v, new_v;
      old_v = exp_tab[256 * 4 + 10];
      new_v = 8'h3C;
      cfg_data_we = 1'b1; cfg_data_val = 16'h3C00;
      in_valid = 1'b1; in_chan = 2'd1; in_r = 8'd0; in_g = 8'd10; in_b = 8'd0;
      @(negedge clk);
      cfg_data_we = 1'b0; in_valid = 1'b0;
      check(int'(out_g) == old_v, "R11", "same-cycle read", out_g, old_v);
      exp_tab[256 * 4 + 10] = new_v;
      pix_check(1, 0, 10, 0, 0, 0, "R11");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule